// File: doc/BRIEF.md
# Aperture Address Remapping Walker

This block sits on the path of incoming bus addresses and redirects those that land inside a programmable aperture window to physical pages chosen by a table held in memory. Every 4 KB page of the window has one 32-bit entry in that table. A request whose page is not in the small on-chip translation cache causes a single read of the entry through a memory read port. A valid entry produces a 40-bit physical address. An entry without its valid bit produces an error response and sets a sticky error flag.

Software configures the window through four 32-bit registers: window control, window base, table base and cache control. Software fills the table itself and must request a cache invalidation after changing entries or the window layout. Addresses outside the window, and all addresses while translation is disabled, are returned unchanged without touching memory. Only one request is in flight at a time. A response is a single-cycle pulse.

Top module: `aper_remap_walker`

## Requirements
- R1: After reset every configuration register reads zero, `req_ready` is high, and `rsp_valid` and `mem_req` are low.
- R2: Register 0 holds the enable in bit 0 and the size order in bits 3:1, and its bits 5:4 always read zero. Register 1 holds a 15-bit base field in bits 14:0. Register 2 holds the table page number (table physical address divided by 4096) in bits 31:4. All other bits read zero.
- R3: With the enable clear, or for an address outside the window, the block returns the request address unchanged with `rsp_err` low one cycle after acceptance and issues no memory read.
- R4: The window starts at the base field times 2^25 and spans 2^25 times 2^order bytes. The start is inside and the end is outside.
- R5: A miss raises `mem_req` for exactly one cycle, one cycle after acceptance, at address table_page*4096 + ((addr - window start) / 4096) * 4.
- R6: A valid entry (bit 0 set) yields the physical address {entry[11:4], entry[31:12], addr[11:0]}, with `rsp_valid` high the cycle after `mem_rvalid`. Entry bits 3:1 do not affect the result.
- R7: An entry with bit 0 clear yields `rsp_err` high with `rsp_addr` zero and sets bit 1 of register 3. Writing 1 to that bit clears it. Invalid entries are never cached.
- R8: A request to a cached page responds one cycle after acceptance with no memory read. The cache holds CACHE_DEPTH pages and evicts the oldest fill.
- R9: Writing 1 to bit 0 of register 3 sets that bit. The bit reads 1 until the block is idle, then self-clears one cycle later, and every cached page is dropped.
- R10: `req_ready` is low while a table read is outstanding and while an invalidation is pending, so a request made then waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_addr | input | 40 | Incoming bus address |
| rsp_valid | output | 1 | Response pulse |
| rsp_addr | output | 40 | Translated or passed-through address |
| rsp_err | output | 1 | Table entry was invalid |
| mem_req | output | 1 | Table read request pulse |
| mem_addr | output | 40 | Table entry address |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 32 | Table entry |

## Verification
The bench builds the block with a two-page cache. With that size, eviction of the oldest page appears after only three distinct misses, and a page that was evicted can be shown to fetch again. Table reads answer after two cycles, so the stalled-ready window during a walk is more than one cycle long. The window is exercised at size orders 0 and 3, which puts both the last page of the smallest window and an offset beyond 32 MB within reach.

// File: rtl/aper_remap_pkg.sv
package aper_remap_pkg;
  localparam int BUS_AW     = 40;
  localparam int DATA_W     = 32;
  localparam int PG_BITS    = 12;
  localparam int FRAME_W    = BUS_AW - PG_BITS;
  localparam int WIN_SHIFT  = 25;
  localparam int BASE_FLD_W = BUS_AW - WIN_SHIFT;
  localparam int ORDER_W    = 3;
  localparam int IDX_W      = WIN_SHIFT + (1 << ORDER_W) - 1 - PG_BITS;
  localparam int ENT_SH     = 2;
  localparam int HI_W       = BUS_AW - DATA_W;
  localparam int TBL_LSB    = 4;
  localparam int CFG_AW     = 2;

  typedef enum logic [CFG_AW-1:0] {
    REG_WIN_CTL   = 2'd0,
    REG_WIN_BASE  = 2'd1,
    REG_TBL_BASE  = 2'd2,
    REG_CACHE_CTL = 2'd3
  } cfg_reg_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_st_e;

  typedef struct packed {
    logic               vld;
    logic [IDX_W-1:0]   tag;
    logic [FRAME_W-1:0] frame;
  } cache_line_t;
endpackage

// File: rtl/aper_cfg_regs.sv
module aper_cfg_regs
  import aper_remap_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we_i,
  input  logic [CFG_AW-1:0]     cfg_addr_i,
  input  logic [DATA_W-1:0]     cfg_wdata_i,
  output logic [DATA_W-1:0]     cfg_rdata_o,
  output logic                  xl_en_o,
  output logic [ORDER_W-1:0]    win_order_o,
  output logic [BASE_FLD_W-1:0] win_base_o,
  output logic [FRAME_W-1:0]    tbl_pn_o,
  output logic                  flush_busy_o,
  input  logic                  flush_done_i,
  input  logic                  walk_err_set_i
);
  logic                  en_q, en_d;
  logic [ORDER_W-1:0]    ord_q, ord_d;
  logic [BASE_FLD_W-1:0] base_q, base_d;
  logic [FRAME_W-1:0]    tbl_q, tbl_d;
  logic                  flush_q, flush_d;
  logic                  err_q, err_d;

  always_comb begin
    en_d    = en_q;
    ord_d   = ord_q;
    base_d  = base_q;
    tbl_d   = tbl_q;
    flush_d = flush_q;
    err_d   = err_q;
    if (flush_done_i) flush_d = 1'b0;
    if (cfg_we_i) begin
      unique case (cfg_reg_e'(cfg_addr_i))
        REG_WIN_CTL: begin
          en_d  = cfg_wdata_i[0];
          ord_d = cfg_wdata_i[ORDER_W:1];
        end
        REG_WIN_BASE:  base_d = cfg_wdata_i[BASE_FLD_W-1:0];
        REG_TBL_BASE:  tbl_d  = cfg_wdata_i[TBL_LSB +: FRAME_W];
        REG_CACHE_CTL: begin
          if (cfg_wdata_i[0]) flush_d = 1'b1;
          if (cfg_wdata_i[1]) err_d   = 1'b0;
        end
      endcase
    end
    if (walk_err_set_i) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ord_q   <= '0;
      base_q  <= '0;
      tbl_q   <= '0;
      flush_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      ord_q   <= ord_d;
      base_q  <= base_d;
      tbl_q   <= tbl_d;
      flush_q <= flush_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    unique case (cfg_reg_e'(cfg_addr_i))
      REG_WIN_CTL:   cfg_rdata_o[ORDER_W:0] = {ord_q, en_q};
      REG_WIN_BASE:  cfg_rdata_o[BASE_FLD_W-1:0] = base_q;
      REG_TBL_BASE:  cfg_rdata_o[TBL_LSB +: FRAME_W] = tbl_q;
      REG_CACHE_CTL: cfg_rdata_o[1:0] = {err_q, flush_q};
    endcase
  end

  assign xl_en_o      = en_q;
  assign win_order_o  = ord_q;
  assign win_base_o   = base_q;
  assign tbl_pn_o     = tbl_q;
  assign flush_busy_o = flush_q;

  AST_FLUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q && !flush_done_i |=> flush_q); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    walk_err_set_i |=> err_q); // R7
endmodule

// File: rtl/aper_xlate_cache.sv
module aper_xlate_cache
  import aper_remap_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   lk_tag_i,
  output logic               hit_o,
  output logic [FRAME_W-1:0] hit_frame_o,
  input  logic               fill_en_i,
  input  logic [IDX_W-1:0]   fill_tag_i,
  input  logic [FRAME_W-1:0] fill_frame_i,
  input  logic               inval_i
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  cache_line_t      lines_q [DEPTH];
  cache_line_t      lines_d [DEPTH];
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [DEPTH-1:0] hit_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = lines_q[g].vld && (lines_q[g].tag == lk_tag_i);
  end

  assign hit_o = |hit_vec;

  always_comb begin
    hit_frame_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i]) hit_frame_o = hit_frame_o | lines_q[i].frame;
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    for (int i = 0; i < DEPTH; i++) lines_d[i] = lines_q[i];
    if (inval_i) begin
      for (int i = 0; i < DEPTH; i++) lines_d[i].vld = 1'b0;
    end else if (fill_en_i) begin
      lines_d[ptr_q].vld   = 1'b1;
      lines_d[ptr_q].tag   = fill_tag_i;
      lines_d[ptr_q].frame = fill_frame_i;
      ptr_d = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) lines_q[i] <= '0;
    end else begin
      ptr_q <= ptr_d;
      for (int i = 0; i < DEPTH; i++) lines_q[i] <= lines_d[i];
    end
  end

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R8
  AST_INVAL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    inval_i |=> !hit_o); // R9
endmodule

// File: rtl/aper_walk_ctrl.sv
module aper_walk_ctrl
  import aper_remap_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [BUS_AW-1:0]     req_addr_i,
  output logic                  rsp_valid_o,
  output logic [BUS_AW-1:0]     rsp_addr_o,
  output logic                  rsp_err_o,
  output logic                  mem_req_o,
  output logic [BUS_AW-1:0]     mem_addr_o,
  input  logic                  mem_rvalid_i,
  input  logic [DATA_W-1:0]     mem_rdata_i,
  input  logic                  xl_en_i,
  input  logic [ORDER_W-1:0]    win_order_i,
  input  logic [BASE_FLD_W-1:0] win_base_i,
  input  logic [FRAME_W-1:0]    tbl_pn_i,
  input  logic                  flush_busy_i,
  output logic                  flush_done_o,
  output logic                  walk_err_set_o,
  output logic [IDX_W-1:0]      lk_tag_o,
  input  logic                  hit_i,
  input  logic [FRAME_W-1:0]    hit_frame_i,
  output logic                  fill_en_o,
  output logic [IDX_W-1:0]      fill_tag_o,
  output logic [FRAME_W-1:0]    fill_frame_o
);
  walk_st_e            st_q, st_d;
  logic                rsp_v_q, rsp_v_d;
  logic [BUS_AW-1:0]   rsp_a_q, rsp_a_d;
  logic                rsp_e_q, rsp_e_d;
  logic                mreq_q, mreq_d;
  logic [BUS_AW-1:0]   maddr_q, maddr_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [PG_BITS-1:0]  lo_q, lo_d;

  logic [BUS_AW-1:0]   win_start;
  logic [BUS_AW:0]     off;
  logic [BUS_AW-1:0]   off_pages;
  logic                in_win;
  logic [IDX_W-1:0]    idx;
  logic [BUS_AW-1:0]   tbl_addr;
  logic                accept;
  logic [2:0]          unused_ent;

  assign win_start = {win_base_i, {WIN_SHIFT{1'b0}}};
  assign off       = {1'b0, req_addr_i} - {1'b0, win_start};
  assign off_pages = (off[BUS_AW-1:0] >> WIN_SHIFT) >> win_order_i;
  assign in_win    = xl_en_i && !off[BUS_AW] && (off_pages == '0);
  assign idx       = off[PG_BITS +: IDX_W];
  assign tbl_addr  = {tbl_pn_i, {PG_BITS{1'b0}}}
                   + {{(BUS_AW-IDX_W-ENT_SH){1'b0}}, idx, {ENT_SH{1'b0}}};

  assign req_ready_o  = (st_q == ST_IDLE) && !flush_busy_i;
  assign flush_done_o = (st_q == ST_IDLE) && flush_busy_i;
  assign accept       = req_valid_i && req_ready_o;
  assign lk_tag_o     = idx;
  assign fill_tag_o   = idx_q;
  assign fill_frame_o = {mem_rdata_i[PG_BITS-1:TBL_LSB], mem_rdata_i[DATA_W-1:PG_BITS]};
  assign unused_ent   = mem_rdata_i[3:1];

  always_comb begin
    st_d           = st_q;
    rsp_v_d        = 1'b0;
    rsp_a_d        = rsp_a_q;
    rsp_e_d        = 1'b0;
    mreq_d         = 1'b0;
    maddr_d        = maddr_q;
    idx_d          = idx_q;
    lo_d           = lo_q;
    fill_en_o      = 1'b0;
    walk_err_set_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (!in_win) begin
            rsp_v_d = 1'b1;
            rsp_a_d = req_addr_i;
          end else if (hit_i) begin
            rsp_v_d = 1'b1;
            rsp_a_d = {hit_frame_i, req_addr_i[PG_BITS-1:0]};
          end else begin
            mreq_d  = 1'b1;
            maddr_d = tbl_addr;
            idx_d   = idx;
            lo_d    = req_addr_i[PG_BITS-1:0];
            st_d    = ST_WALK;
          end
        end
      end
      ST_WALK: begin
        if (mem_rvalid_i) begin
          st_d    = ST_IDLE;
          rsp_v_d = 1'b1;
          if (mem_rdata_i[0]) begin
            rsp_a_d   = {fill_frame_o, lo_q};
            fill_en_o = 1'b1;
          end else begin
            rsp_a_d        = '0;
            rsp_e_d        = 1'b1;
            walk_err_set_o = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rsp_v_q <= 1'b0;
      rsp_a_q <= '0;
      rsp_e_q <= 1'b0;
      mreq_q  <= 1'b0;
      maddr_q <= '0;
      idx_q   <= '0;
      lo_q    <= '0;
    end else begin
      st_q    <= st_d;
      rsp_v_q <= rsp_v_d;
      rsp_a_q <= rsp_a_d;
      rsp_e_q <= rsp_e_d;
      mreq_q  <= mreq_d;
      maddr_q <= maddr_d;
      idx_q   <= idx_d;
      lo_q    <= lo_d;
    end
  end

  assign rsp_valid_o = rsp_v_q;
  assign rsp_addr_o  = rsp_a_q;
  assign rsp_err_o   = rsp_e_q;
  assign mem_req_o   = mreq_q;
  assign mem_addr_o  = maddr_q;

  AST_BYPASS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_win |=> rsp_valid_o && !rsp_err_o && (rsp_addr_o == $past(req_addr_i))); // R3
  AST_ERR_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && rsp_err_o |-> (rsp_addr_o == '0)); // R7
  AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_win && hit_i |=> rsp_valid_o && !mem_req_o); // R8
  AST_WALK_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o && !req_ready_o); // R10
endmodule

// File: rtl/aper_remap_walker.sv
module aper_remap_walker
  import aper_remap_pkg::*;
#(
  parameter int CACHE_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [39:0]       req_addr,
  output logic              rsp_valid,
  output logic [39:0]       rsp_addr,
  output logic              rsp_err,
  output logic              mem_req,
  output logic [39:0]       mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata
);
  logic                  xl_en;
  logic [ORDER_W-1:0]    win_order;
  logic [BASE_FLD_W-1:0] win_base;
  logic [FRAME_W-1:0]    tbl_pn;
  logic                  flush_busy;
  logic                  flush_done;
  logic                  walk_err_set;
  logic [IDX_W-1:0]      lk_tag;
  logic                  hit;
  logic [FRAME_W-1:0]    hit_frame;
  logic                  fill_en;
  logic [IDX_W-1:0]      fill_tag;
  logic [FRAME_W-1:0]    fill_frame;

  aper_cfg_regs u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_we_i       (cfg_we),
    .cfg_addr_i     (cfg_addr),
    .cfg_wdata_i    (cfg_wdata),
    .cfg_rdata_o    (cfg_rdata),
    .xl_en_o        (xl_en),
    .win_order_o    (win_order),
    .win_base_o     (win_base),
    .tbl_pn_o       (tbl_pn),
    .flush_busy_o   (flush_busy),
    .flush_done_i   (flush_done),
    .walk_err_set_i (walk_err_set)
  );

  aper_xlate_cache #(.DEPTH(CACHE_DEPTH)) u_cache (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_tag_i     (lk_tag),
    .hit_o        (hit),
    .hit_frame_o  (hit_frame),
    .fill_en_i    (fill_en),
    .fill_tag_i   (fill_tag),
    .fill_frame_i (fill_frame),
    .inval_i      (flush_done)
  );

  aper_walk_ctrl u_walk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid_i    (req_valid),
    .req_ready_o    (req_ready),
    .req_addr_i     (req_addr),
    .rsp_valid_o    (rsp_valid),
    .rsp_addr_o     (rsp_addr),
    .rsp_err_o      (rsp_err),
    .mem_req_o      (mem_req),
    .mem_addr_o     (mem_addr),
    .mem_rvalid_i   (mem_rvalid),
    .mem_rdata_i    (mem_rdata),
    .xl_en_i        (xl_en),
    .win_order_i    (win_order),
    .win_base_i     (win_base),
    .tbl_pn_i       (tbl_pn),
    .flush_busy_i   (flush_busy),
    .flush_done_o   (flush_done),
    .walk_err_set_o (walk_err_set),
    .lk_tag_o       (lk_tag),
    .hit_i          (hit),
    .hit_frame_i    (hit_frame),
    .fill_en_o      (fill_en),
    .fill_tag_o     (fill_tag),
    .fill_frame_o   (fill_frame)
  );

  AST_NO_ACCEPT_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |-> !flush_busy); // R10
endmodule

// File: tb/aper_remap_walker_bench.sv
module aper_remap_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 2;
  localparam int MEM_LAT    = 2;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [39:0] req_addr = '0;
  logic        rsp_valid;
  logic [39:0] rsp_addr;
  logic        rsp_err;
  logic        mem_req;
  logic [39:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int last_stalls = 0;

  // reference model state
  bit          m_en = 1'b0;
  logic [2:0]  m_order = '0;
  logic [63:0] m_base = '0;
  logic [63:0] m_tbl = '0;
  logic [31:0] mem_m [logic [39:0]];
  int unsigned cq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  aper_remap_walker #(.CACHE_DEPTH(DEPTH)) u_aper_remap_walker (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_addr(rsp_addr), .rsp_err(rsp_err), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  task automatic check(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s got %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] win_lo();
    return m_base << 25;
  endfunction

  function automatic logic [63:0] win_sz();
    return 64'd33554432 << m_order;
  endfunction

  function automatic bit in_win(input logic [39:0] a);
    return m_en && ({24'd0, a} >= win_lo()) && ({24'd0, a} < win_lo() + win_sz());
  endfunction

  function automatic logic [39:0] ent_addr(input int unsigned ix);
    logic [63:0] t;
    t = (m_tbl << 12) + 64'(ix) * 4;
    return t[39:0];
  endfunction

  function automatic logic [31:0] ent_of(input logic [39:0] ea);
    if (mem_m.exists(ea)) return mem_m[ea];
    return 32'h0;
  endfunction

  task automatic set_entry(input int unsigned ix, input logic [31:0] v);
    mem_m[ent_addr(ix)] = v;
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      2'd0: begin m_en = d[0]; m_order = d[3:1]; end
      2'd1: m_base = {49'd0, d[14:0]};
      2'd2: m_tbl = {36'd0, d[31:4]};
      default: if (d[0]) cq.delete();
    endcase
  endtask

  task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic do_req(input logic [39:0] a, input bit no_wait);
    bit inw, hit;
    int unsigned ix;
    logic [39:0] ea, exp_a;
    logic [31:0] e;
    int stalls;
    inw = in_win(a);
    ix = 0;
    if (inw) ix = int'(({24'd0, a} - win_lo()) >> 12);
    hit = 1'b0;
    foreach (cq[k]) if (inw && cq[k] == ix) hit = 1'b1;
    ea = ent_addr(ix);
    e = ent_of(ea);
    if (!no_wait) @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    stalls = 0;
    #1;
    while (!req_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    last_stalls = stalls;
    @(negedge clk);
    req_valid = 1'b0;
    if (!inw || hit) begin
      exp_a = inw ? {e[11:4], e[31:12], a[11:0]} : a;
      check(inw ? "R8" : "R3", "rsp_valid next cycle", 64'(rsp_valid), 64'd1);
      check(inw ? "R8" : "R3", "rsp_addr", 64'(rsp_addr), 64'(exp_a));
      check(inw ? "R8" : "R3", "no fetch / no error", 64'({mem_req, rsp_err}), 64'd0);
    end else begin
      check("R5", "mem_req after accept", 64'(mem_req), 64'd1);
      check("R5", "mem_addr", 64'(mem_addr), 64'(ea));
      check("R5", "no early rsp", 64'(rsp_valid), 64'd0);
      for (int c = 0; c < MEM_LAT; c++) begin
        @(negedge clk);
        check("R10", "walk: {mem_req,req_ready,rsp_valid}",
              64'({mem_req, req_ready, rsp_valid}), 64'd0);
      end
      mem_rvalid = 1'b1; mem_rdata = e;
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (e[0]) begin
        exp_a = {e[11:4], e[31:12], a[11:0]};
        check("R6", "rsp_valid after read", 64'(rsp_valid), 64'd1);
        check("R6", "rsp_addr decoded", 64'(rsp_addr), 64'(exp_a));
        check("R6", "rsp_err", 64'(rsp_err), 64'd0);
        cq.push_back(ix);
        if (cq.size() > DEPTH) void'(cq.pop_front());
      end else begin
        check("R7", "{rsp_valid,rsp_err}", 64'({rsp_valid, rsp_err}), 64'h3);
        check("R7", "rsp_addr on error", 64'(rsp_addr), 64'd0);
      end
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish got %0d expected %0d", WD_CYCLES, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [39:0] wb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "{req_ready,rsp_valid,mem_req}", 64'({req_ready, rsp_valid, mem_req}), 64'h4);
    for (int r = 0; r < 4; r++) begin
      cfg_read(2'(r), rd);
      check("R1", "register after reset", 64'(rd), 64'd0);
    end

    // R2 register layout
    cfg_write(2'd0, 32'hFFFF_FF3F);
    cfg_read(2'd0, rd);
    check("R2", "window control readback", 64'(rd), 64'h0F);
    cfg_write(2'd1, 32'hFFFF_FFFF);
    cfg_read(2'd1, rd);
    check("R2", "window base readback", 64'(rd), 64'h7FFF);
    cfg_write(2'd0, 32'h1);
    cfg_write(2'd1, 32'h2);
    cfg_write(2'd2, 32'h0123_4567);
    cfg_read(2'd2, rd);
    check("R2", "table base readback", 64'(rd), 64'h0123_4560);

    set_entry(5, 32'hCDEF_1AB3);
    set_entry(32'h1FFF, 32'h1357_9F0F);
    set_entry(7, 32'h2468_A011);
    set_entry(9, 32'h0000_0FF0);
    set_entry(32'h8000, 32'h0BEE_F0C1);

    wb = 40'h00_0400_0000;
    // R3/R4 bypass cases around the window
    do_req(wb - 40'd4, 1'b0);                 // R4 just below start
    do_req(wb + 40'h200_0000, 1'b0);          // R4 end is outside
    do_req(40'h01_0000_0000, 1'b0);           // R3 far outside
    // R5/R6 miss then R8 hit
    do_req(wb + 40'h5ABC, 1'b0);
    do_req(wb + 40'h5123, 1'b0);
    do_req(wb + 40'h1FF_FFFF, 1'b0);          // R4 last page inside
    // R8 eviction of oldest
    do_req(wb + 40'h7004, 1'b0);
    do_req(wb + 40'h1FF_F010, 1'b0);
    do_req(wb + 40'h5000, 1'b0);
    // R7 invalid entry, not cached, sticky W1C flag
    do_req(wb + 40'h9008, 1'b0);
    cfg_read(2'd3, rd);
    check("R7", "walk error flag", 64'(rd[1]), 64'd1);
    do_req(wb + 40'h9FFC, 1'b0);
    cfg_write(2'd3, 32'h2);
    cfg_read(2'd3, rd);
    check("R7", "walk error cleared", 64'(rd), 64'd0);

    // R9/R10 flush with stalled request
    cfg_write(2'd3, 32'h1);
    cfg_read(2'd3, rd);
    check("R9", "flush bit while pending", 64'(rd[0]), 64'd1);
    check("R10", "ready low during flush", 64'(req_ready), 64'd0);
    do_req(wb + 40'h5ABC, 1'b1);
    check("R10", "stall cycles for flush", 64'(last_stalls), 64'd1);
    cfg_read(2'd3, rd);
    check("R9", "flush bit self-cleared", 64'(rd[0]), 64'd0);

    // R4 larger order
    cfg_write(2'd0, 32'h7);
    cfg_write(2'd3, 32'h1);
    do_req(wb + 40'h800_0044, 1'b0);
    do_req(wb + 40'h1000_0000, 1'b0);         // R4 end of 256 MB window
    // R3 disabled translation inside window
    cfg_write(2'd0, 32'h6);
    do_req(wb + 40'h5ABC, 1'b0);

    done = 1'b1;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule